// File: doc/BRIEF.md
# Quad-Width Prefix Execution Unit

This unit sits in the execute path of an 8-bit processor. It handles a small group of memory-operand operations: load, store, add with carry, bitwise AND and exclusive-OR. Each one either works on the accumulator A alone or on a 32-bit "quad" value formed from the four byte registers A, X, Y and Z. The instruction stream arrives one opcode byte per cycle with a valid strobe. A pair of consecutive prefix bytes (0x42, 0x42) widens the next instruction to the full 32 bits. The prefix then lapses.

Operand address bytes are consumed elsewhere, so only opcode and prefix bytes appear on the byte input. The operand fetched from memory arrives already assembled on a 32-bit input, sampled together with the opcode. The incoming carry flag arrives the same way. The unit registers the decoded operation and operand first, and runs the lane-chained arithmetic in a second stage. This keeps decode and input routing out of the path from the register file, through the 32-bit carry chain, and back to the register file.

Top module: `quad_exec_unit`

## Requirements
- R1: After synchronous reset, quad_q, flag_n, flag_z, flag_c, result_valid and store_valid are all zero.
- R2: Two consecutive valid 0x42 bytes make the next valid byte a 32-bit instruction (result_wide high with its result). The prefix then clears, so the following instruction is 8-bit again.
- R3: A single valid 0x42 followed by any other valid byte keeps no prefix state, and that byte executes at 8-bit width.
- R4: The quad register is little-endian: A = bits 7:0, X = 15:8, Y = 23:16, Z = 31:24. An 8-bit instruction never changes bits 31:8.
- R5: Opcode map: 0xAD load, 0x8D store, 0x6D add with carry, 0x2D AND, 0x4D exclusive-OR. Any other opcode produces no result and changes no state. It still consumes a pending prefix.
- R6: A 32-bit add computes quad + operand + carry_in, with the carry rippling across all four byte lanes. flag_c takes the carry out of bit 31. Examples: 0x12345678+0x0DCBA989 gives 0x20000001, and 0x12345678+0xFF gives 0x12345777.
- R7: An 8-bit add computes A + operand[7:0] + carry_in. flag_c takes the carry out of bit 7.
- R8: Load, add, AND and exclusive-OR set flag_n from the top bit of the active width. They set flag_z when the active width of the result is all zero. flag_c changes only on add. A store changes no flag.
- R9: A valid opcode byte sampled at clock edge k gives its result, flags and a one-cycle result_valid at edge k+1.
- R10: A store raises store_valid with result_valid. store_data is the full quad when wide, or {24'b0, A} when narrow. The quad register is unchanged.
- R11: Bytes with op_valid low are ignored. A pending prefix persists across such idle cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | input | 1 | op_byte holds a stream byte this cycle |
| op_byte | input | 8 | Prefix or opcode byte |
| mem_operand | input | 32 | Assembled memory operand, sampled with the opcode |
| carry_in | input | 1 | Carry flag entering an add |
| quad_q | output | 32 | Quad register {Z, Y, X, A} |
| flag_n | output | 1 | Negative flag |
| flag_z | output | 1 | Zero flag |
| flag_c | output | 1 | Carry flag from the last add |
| result_valid | output | 1 | One-cycle pulse when an instruction completes |
| result_wide | output | 1 | Completed instruction was 32-bit |
| store_valid | output | 1 | Completed instruction was a store |
| store_data | output | 32 | Value to write for a store |

## Verification
The assertions assume that op_valid is driven to a known level from reset onward. They also assume that mem_operand and carry_in are only meaningful in the cycle where a valid opcode is sampled. The timing property relies on every result coming from a byte accepted exactly two samples earlier. The stimulus drives all inputs at the falling edge. It holds op_valid low outside the bytes it issues, and presents operand and carry only alongside opcodes. Back-to-back opcodes test that each result reads the quad value written by its predecessor.

// File: rtl/quad_pkg.sv
package quad_pkg;
  localparam logic [7:0] PREFIX_BYTE = 8'h42;
  localparam logic [7:0] OPC_LOAD    = 8'hAD;
  localparam logic [7:0] OPC_STORE   = 8'h8D;
  localparam logic [7:0] OPC_ADC     = 8'h6D;
  localparam logic [7:0] OPC_AND     = 8'h2D;
  localparam logic [7:0] OPC_EOR     = 8'h4D;

  typedef enum logic [2:0] {
    OP_NONE, OP_LOAD, OP_STORE, OP_ADC, OP_AND, OP_EOR
  } quad_op_e;

  typedef enum logic [1:0] {
    PFX_IDLE, PFX_ONE, PFX_ARMED
  } pfx_state_e;
endpackage

// File: rtl/quad_prefix_tracker.sv
module quad_prefix_tracker
  import quad_pkg::*;
#(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              byte_valid,
  input  logic [BYTE_W-1:0] byte_in,
  output logic              issue_valid,
  output logic              issue_wide
);
  pfx_state_e state_q, state_d;
  logic       is_pfx;

  assign is_pfx = (byte_in == PREFIX_BYTE[BYTE_W-1:0]);

  always_comb begin
    state_d     = state_q;
    issue_valid = 1'b0;
    issue_wide  = 1'b0;
    if (byte_valid) begin
      case (state_q)
        PFX_IDLE: begin
          if (is_pfx) state_d = PFX_ONE;
          else        issue_valid = 1'b1;
        end
        PFX_ONE: begin
          if (is_pfx) begin
            state_d = PFX_ARMED;
          end else begin
            state_d     = PFX_IDLE;
            issue_valid = 1'b1;
          end
        end
        PFX_ARMED: begin
          state_d     = PFX_IDLE;
          issue_valid = 1'b1;
          issue_wide  = 1'b1;
        end
        default: state_d = PFX_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) state_q <= PFX_IDLE;
    else     state_q <= state_d;
  end
endmodule

// File: rtl/quad_decoder.sv
module quad_decoder
  import quad_pkg::*;
#(
  parameter int BYTE_W = 8
) (
  input  logic [BYTE_W-1:0] opcode,
  output quad_op_e          op
);
  always_comb begin
    case (opcode)
      OPC_LOAD:  op = OP_LOAD;
      OPC_STORE: op = OP_STORE;
      OPC_ADC:   op = OP_ADC;
      OPC_AND:   op = OP_AND;
      OPC_EOR:   op = OP_EOR;
      default:   op = OP_NONE;
    endcase
  end
endmodule

// File: rtl/quad_lane_alu.sv
module quad_lane_alu
  import quad_pkg::*;
#(
  parameter int LANES  = 4,
  parameter int LANE_W = 8,
  localparam int QW    = LANES * LANE_W
) (
  input  quad_op_e        op,
  input  logic            wide,
  input  logic [QW-1:0]   quad_in,
  input  logic [QW-1:0]   operand,
  input  logic            cin,
  output logic [QW-1:0]   result,
  output logic            cout,
  output logic            neg,
  output logic            zero
);
  logic [LANES:0] carry;
  assign carry[0] = cin;

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    logic [LANE_W-1:0] a, b, r, sum;
    logic              keep;
    assign a    = quad_in[i*LANE_W +: LANE_W];
    assign b    = operand[i*LANE_W +: LANE_W];
    assign keep = !wide && (i != 0);
    assign {carry[i+1], sum} = {1'b0, a} + {1'b0, b} + {{LANE_W{1'b0}}, carry[i]};
    always_comb begin
      case (op)
        OP_LOAD: r = b;
        OP_ADC:  r = sum;
        OP_AND:  r = a & b;
        OP_EOR:  r = a ^ b;
        default: r = a;
      endcase
    end
    assign result[i*LANE_W +: LANE_W] = keep ? a : r;
  end

  assign cout = wide ? carry[LANES] : carry[1];
  assign neg  = wide ? result[QW-1] : result[LANE_W-1];
  assign zero = wide ? (result == '0) : (result[LANE_W-1:0] == '0);
endmodule

// File: rtl/quad_exec_unit.sv
module quad_exec_unit
  import quad_pkg::*;
#(
  parameter int LANES  = 4,
  parameter int LANE_W = 8,
  localparam int QW    = LANES * LANE_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              op_valid,
  input  logic [LANE_W-1:0] op_byte,
  input  logic [QW-1:0]     mem_operand,
  input  logic              carry_in,
  output logic [QW-1:0]     quad_q,
  output logic              flag_n,
  output logic              flag_z,
  output logic              flag_c,
  output logic              result_valid,
  output logic              result_wide,
  output logic              store_valid,
  output logic [QW-1:0]     store_data
);
  logic     issue_valid, issue_wide;
  quad_op_e dec_op;

  quad_prefix_tracker #(.BYTE_W(LANE_W)) u_pfx (
    .clk(clk), .rst(rst), .byte_valid(op_valid), .byte_in(op_byte),
    .issue_valid(issue_valid), .issue_wide(issue_wide)
  );

  quad_decoder #(.BYTE_W(LANE_W)) u_dec (.opcode(op_byte), .op(dec_op));

  // Stage 1: decoded operation and operand
  logic          s1_valid, s1_wide, s1_cin;
  quad_op_e      s1_op;
  logic [QW-1:0] s1_operand;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_valid   <= 1'b0;
      s1_wide    <= 1'b0;
      s1_cin     <= 1'b0;
      s1_op      <= OP_NONE;
      s1_operand <= '0;
    end else begin
      s1_valid <= issue_valid && (dec_op != OP_NONE);
      if (issue_valid) begin
        s1_wide    <= issue_wide;
        s1_op      <= dec_op;
        s1_cin     <= carry_in;
        s1_operand <= mem_operand;
      end
    end
  end

  // Stage 2: lane-chained ALU and register write-back
  logic [QW-1:0] alu_res;
  logic          alu_c, alu_n, alu_z;

  quad_lane_alu #(.LANES(LANES), .LANE_W(LANE_W)) u_alu (
    .op(s1_op), .wide(s1_wide), .quad_in(quad_q), .operand(s1_operand),
    .cin(s1_cin), .result(alu_res), .cout(alu_c), .neg(alu_n), .zero(alu_z)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      quad_q       <= '0;
      flag_n       <= 1'b0;
      flag_z       <= 1'b0;
      flag_c       <= 1'b0;
      result_valid <= 1'b0;
      result_wide  <= 1'b0;
      store_valid  <= 1'b0;
      store_data   <= '0;
    end else begin
      result_valid <= s1_valid;
      store_valid  <= s1_valid && (s1_op == OP_STORE);
      if (s1_valid) begin
        result_wide <= s1_wide;
        if (s1_op == OP_STORE) begin
          store_data <= s1_wide ? quad_q : {{(QW-LANE_W){1'b0}}, quad_q[LANE_W-1:0]};
        end else begin
          quad_q <= alu_res;
          flag_n <= alu_n;
          flag_z <= alu_z;
          if (s1_op == OP_ADC) flag_c <= alu_c;
        end
      end
    end
  end
endmodule

// File: rtl/quad_exec_checker.sv
module quad_exec_checker #(
  parameter int QW     = 32,
  parameter int LANE_W = 8
) (
  input logic          clk,
  input logic          rst,
  input logic          op_valid,
  input logic          result_valid,
  input logic          result_wide,
  input logic          store_valid,
  input logic [QW-1:0] quad_q,
  input logic          flag_c
);
  // R1
  reset_clear_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> !result_valid && !store_valid);

  // R9
  result_timing_chk: assert property (@(posedge clk) disable iff (rst)
    result_valid |-> $past(op_valid, 2));

  // R4
  narrow_upper_chk: assert property (@(posedge clk) disable iff (rst)
    (result_valid && !result_wide) |-> quad_q[QW-1:LANE_W] == $past(quad_q[QW-1:LANE_W]));

  // R11
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !result_valid |-> $stable(quad_q) && $stable(flag_c));

  // R10
  store_keep_chk: assert property (@(posedge clk) disable iff (rst)
    store_valid |-> result_valid && $stable(quad_q));
endmodule

bind quad_exec_unit quad_exec_checker #(.QW(QW), .LANE_W(LANE_W)) u_chk (
  .clk(clk), .rst(rst), .op_valid(op_valid), .result_valid(result_valid),
  .result_wide(result_wide), .store_valid(store_valid), .quad_q(quad_q),
  .flag_c(flag_c)
);

// File: tb/quad_exec_unit_test.sv
module quad_exec_unit_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        op_valid = 1'b0;
  logic [7:0]  op_byte = 8'h00;
  logic [31:0] mem_operand = '0;
  logic        carry_in = 1'b0;
  logic [31:0] quad_q, store_data;
  logic        flag_n, flag_z, flag_c, result_valid, result_wide, store_valid;

  quad_exec_unit uut (
    .clk(clk), .rst(rst), .op_valid(op_valid), .op_byte(op_byte),
    .mem_operand(mem_operand), .carry_in(carry_in), .quad_q(quad_q),
    .flag_n(flag_n), .flag_z(flag_z), .flag_c(flag_c),
    .result_valid(result_valid), .result_wide(result_wide),
    .store_valid(store_valid), .store_data(store_data)
  );

  always #2 clk = ~clk;

  typedef struct {
    logic [31:0] q;
    logic n, z, c, wide, st;
    logic [31:0] sd;
    int due;
    string tag;
  } exp_t;

  exp_t exp_q[$];
  int checks = 0, errors = 0, cyc = 0;
  int pstate = 0;
  logic [31:0] rq = '0;
  logic rn = 0, rz = 0, rc = 0;
  bit done = 0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [63:0] act, input logic [63:0] expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, expv);
    end
  endtask

  // Driver: one stream byte per call, reference model updated in order
  task automatic put(input logic [7:0] b, input logic [31:0] opd, input logic cin,
                     input string tag);
    bit issue = 0, wide = 0;
    exp_t e;
    @(negedge clk);
    op_valid = 1'b1; op_byte = b; mem_operand = opd; carry_in = cin;
    case (pstate)
      0: if (b == 8'h42) pstate = 1; else issue = 1;
      1: if (b == 8'h42) pstate = 2; else begin pstate = 0; issue = 1; end
      default: begin pstate = 0; issue = 1; wide = 1; end
    endcase
    if (issue && (b == 8'hAD || b == 8'h8D || b == 8'h6D || b == 8'h2D || b == 8'h4D)) begin
      e.st = 0; e.sd = '0;
      case (b)
        8'hAD: rq = wide ? opd : {rq[31:8], opd[7:0]};
        8'h6D: begin
          if (wide) {rc, rq} = {1'b0, rq} + {1'b0, opd} + 33'(cin);
          else begin
            logic [8:0] s9;
            s9 = {1'b0, rq[7:0]} + {1'b0, opd[7:0]} + 9'(cin);
            rq[7:0] = s9[7:0]; rc = s9[8];
          end
        end
        8'h2D: rq = wide ? (rq & opd) : {rq[31:8], rq[7:0] & opd[7:0]};
        8'h4D: rq = wide ? (rq ^ opd) : {rq[31:8], rq[7:0] ^ opd[7:0]};
        default: begin e.st = 1; e.sd = wide ? rq : {24'h0, rq[7:0]}; end
      endcase
      if (b != 8'h8D) begin
        rn = wide ? rq[31] : rq[7];
        rz = wide ? (rq == 0) : (rq[7:0] == 0);
      end
      e.q = rq; e.n = rn; e.z = rz; e.c = rc; e.wide = wide;
      e.due = cyc + 2; e.tag = tag;
      exp_q.push_back(e);
    end
  endtask

  task automatic pfx();
    put(8'h42, 32'h0, 1'b0, "R2");
    put(8'h42, 32'h0, 1'b0, "R2");
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      op_valid = 1'b0; op_byte = 8'hAD; mem_operand = 32'hDEADBEEF; carry_in = 1'b1;
    end
  endtask

  // Monitor: pops the scoreboard whenever a result appears
  always @(negedge clk) begin
    if (!rst && result_valid) begin
      if (exp_q.size() == 0) begin
        check(0, "R5", "unexpected result_valid", 1, 0);
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        check(cyc == e.due, "R9", "result cycle", 64'(cyc), 64'(e.due));
        check(quad_q == e.q, e.tag, "quad", 64'(quad_q), 64'(e.q));
        check({flag_n, flag_z, flag_c} == {e.n, e.z, e.c}, "R8", "flags NZC",
              64'({flag_n, flag_z, flag_c}), 64'({e.n, e.z, e.c}));
        check(result_wide == e.wide, "R2", "width", 64'(result_wide), 64'(e.wide));
        check(store_valid == e.st, "R10", "store_valid", 64'(store_valid), 64'(e.st));
        if (e.st) check(store_data == e.sd, "R10", "store_data", 64'(store_data), 64'(e.sd));
      end
    end
  end

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      check(0, "R9", "watchdog expired", 0, 1);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    check(quad_q == 0 && {flag_n, flag_z, flag_c} == 0, "R1", "reset regs",
          64'({quad_q, flag_n, flag_z, flag_c}), 0);
    check(!result_valid && !store_valid, "R1", "reset strobes",
          64'({result_valid, store_valid}), 0);

    put(8'hAD, 32'hFFFFFF80, 1'b0, "R4");            // narrow load, N set
    pfx(); put(8'hAD, 32'h12345678, 1'b0, "R2");     // wide load
    pfx(); put(8'h6D, 32'h0DCBA989, 1'b0, "R6");     // 0x20000001
    idle(3);
    check(quad_q == 32'h20000001, "R6", "long carry", 64'(quad_q), 64'h20000001);
    pfx(); put(8'hAD, 32'h12345678, 1'b0, "R2");
    pfx(); put(8'h6D, 32'h000000FF, 1'b0, "R6");     // 0x12345777
    idle(3);
    check(quad_q == 32'h12345777, "R6", "byte carry", 64'(quad_q), 64'h12345777);
    pfx(); put(8'hAD, 32'h12345678, 1'b0, "R2");
    pfx(); put(8'h6D, 32'h0000FF00, 1'b0, "R6");     // 0x12355578
    pfx(); put(8'h6D, 32'hFFFFFFFF, 1'b1, "R6");     // carry out of bit 31
    put(8'h6D, 32'h000000F0, 1'b1, "R7");            // narrow add, R7 carry out of bit 7
    put(8'h42, 32'h0, 1'b0, "R3");
    put(8'h6D, 32'h00000011, 1'b0, "R3");            // single prefix -> narrow
    pfx(); idle(4); put(8'h4D, 32'hFFFF0000, 1'b0, "R11"); // prefix survives idle
    put(8'h2D, 32'h00000000, 1'b0, "R8");            // narrow AND -> Z
    pfx(); put(8'h2D, 32'h0000FFFF, 1'b0, "R8");
    pfx(); put(8'h8D, 32'h0, 1'b0, "R10");           // wide store
    put(8'h8D, 32'h0, 1'b0, "R10");                  // narrow store
    pfx(); put(8'h00, 32'h0, 1'b0, "R5");            // unknown opcode eats prefix
    put(8'hAD, 32'hA5A5A5A5, 1'b0, "R5");            // must be narrow
    put(8'h4D, 32'h000000FF, 1'b0, "R4");
    idle(5);
    check(exp_q.size() == 0, "R9", "scoreboard drained", 64'(exp_q.size()), 0);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule